// File: doc/BRIEF.md
# Chaotic-Map Random Bit Generator

This block produces a stream of pseudo-random bits from a discretized expanding map. An n-bit state k is read as a binary fraction, and on each enabled step it is replaced by the integer part of β·k, kept modulo 2^n. The multiplier β is a fixed-point word with n integer bits and n fraction bits. It is not a single constant. On every step a small linear feedback shift register picks one of four constants. The four differ only in the top three integer bits, and all of them keep every fraction bit set. Changing the slope from step to step breaks up the short cycles that a fixed-slope map falls into once its state is finite.

Software or a seeding engine loads a start value through the seed port. Each cycle with the enable high then yields one output bit with a valid strobe. A zero seed would stick at the map's fixed point, so the block replaces it with a nonzero default. A seed load also restarts the selector register, so the whole bit stream depends on the seed alone.

Top module: `chaos_bit_gen`

## Requirements
- R1: After reset the valid output is low, the state holds DEFAULT_SEED (16'hACE1 by default) and the selector register holds 5'b00001. Steps taken without a load continue from these values.
- R2: A load with a nonzero seed writes the seed into the state and restarts the selector register at 5'b00001. No valid output appears in the cycle after a load.
- R3: A load whose seed is zero puts DEFAULT_SEED into the state instead of the seed.
- R4: Each enabled step replaces state k with bits [2n-1:n] of the product β·k. β is the 2n-bit word {t[2:0], n-3 zero bits, n one bits}, where t is the selected three-bit code.
- R5: The code index is {sel[4], sel[1]} from the current selector register. Index 0 gives t=3'b111, index 1 gives 3'b011, index 2 gives 3'b110 and index 3 gives 3'b010.
- R6: The selector register advances only on enabled steps, with next = {sel[3:0], sel[4]^sel[2]}. This is the maximal-length polynomial x^5+x^3+1. The register never holds zero.
- R7: One cycle after an enabled step, the valid output is high and the output bit equals the most significant bit of the new state.
- R8: While the enable and the load are both low, the valid output is low and neither the state nor the selector register changes. The stream resumes where it stopped.
- R9: When the load and the enable are high together, the load takes effect and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load seed_val into the state and restart the selector |
| seed_val | input | STATE_W | Start value for the state |
| step_en | input | 1 | Advance the map by one step |
| rnd_bit | output | 1 | Generated bit |
| rnd_valid | output | 1 | rnd_bit carries a new bit |

## Verification
Every result of this block is due exactly one clock edge after the cycle that requests it. A step, an idle cycle or a load each decides the valid strobe and the bit seen after the next rising edge. The driver applies inputs on the falling edge and queues the strobe and bit that the requirements predict for that cycle. The monitor pops one entry a few nanoseconds after each rising edge, so each prediction is compared against the edge that should have produced it. Loss of step alignment, a dropped idle cycle or a wrong slope choice then shows up in the bits that follow.

// File: rtl/chaos_pkg.sv
package chaos_pkg;
   // three-bit slope code for each selector index
   function automatic logic [2:0] slope_code(input logic [1:0] idx);
      case (idx)
         2'd0:    slope_code = 3'b111;
         2'd1:    slope_code = 3'b011;
         2'd2:    slope_code = 3'b110;
         default: slope_code = 3'b010;
      endcase
   endfunction
endpackage

// File: rtl/chaos_lfsr.sv
module chaos_lfsr #(
   parameter int          W    = 5,
   parameter logic [W-1:0] INIT = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         advance,
   output logic [W-1:0] q
);
   logic fb;

   generate
      if (W == 4) begin : g_w4
         assign fb = q[3] ^ q[2];
      end else if (W == 5) begin : g_w5
         assign fb = q[4] ^ q[2];
      end else if (W == 6) begin : g_w6
         assign fb = q[5] ^ q[4];
      end else if (W == 7) begin : g_w7
         assign fb = q[6] ^ q[5];
      end else begin : g_bad
         $error("chaos_lfsr: width %0d has no tap set", W);
         assign fb = 1'b0;
      end
      if (INIT == '0) begin : g_zero_init
         $error("chaos_lfsr: INIT must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= INIT;
      end else if (restart) begin
         q <= INIT;
      end else if (advance) begin
         q <= {q[W-2:0], fb};
      end
   end
endmodule

// File: rtl/chaos_slope_sel.sv
module chaos_slope_sel #(
   parameter int DECODE_STYLE = 1
) (
   input  logic [1:0] idx,
   output logic [2:0] code
);
   import chaos_pkg::*;

   generate
      if (DECODE_STYLE == 0) begin : g_table
         assign code = slope_code(idx);
      end else begin : g_shared
         // codes share the middle bit; the outer bits follow the index
         assign code = {~idx[0], 1'b1, ~idx[1]};
      end
   endgenerate
endmodule

// File: rtl/chaos_map_step.sv
module chaos_map_step #(
   parameter int N         = 16,
   parameter int MAP_STYLE = 0
) (
   input  logic [N-1:0] k,
   input  logic [2:0]   code,
   output logic [N-1:0] k_next
);
   localparam int BW = 2 * N;

   generate
      if (MAP_STYLE == 0) begin : g_full_mult
         logic [BW-1:0] beta;
         logic [BW-1:0] k_ext;
         assign beta   = {code, {(N-3){1'b0}}, {N{1'b1}}};
         assign k_ext  = {{N{1'b0}}, k};
         assign k_next = N'((k_ext * beta) >> N);
      end else begin : g_folded
         // integer part wraps to its top three bits; fraction part gives k-1
         logic [2:0]   wrap;
         logic [N-1:0] dec;
         assign wrap   = code * k[2:0];
         assign dec    = k - N'(k != '0);
         assign k_next = {wrap, {(N-3){1'b0}}} + dec;
      end
   endgenerate
endmodule

// File: rtl/chaos_bit_gen.sv
module chaos_bit_gen #(
   parameter int                 STATE_W      = 16,
   parameter int                 LFSR_W       = 5,
   parameter int                 SEL_HI       = 4,
   parameter int                 SEL_LO       = 1,
   parameter logic [STATE_W-1:0] DEFAULT_SEED = 16'hACE1,
   parameter logic [LFSR_W-1:0]  LFSR_INIT    = 1,
   parameter int                 MAP_STYLE    = 0,
   parameter int                 DECODE_STYLE = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               seed_load,
   input  logic [STATE_W-1:0] seed_val,
   input  logic               step_en,
   output logic               rnd_bit,
   output logic               rnd_valid
);
   localparam int MSB = STATE_W - 1;

   generate
      if (STATE_W < 4) begin : g_chk_w
         $error("chaos_bit_gen: STATE_W must be at least 4");
      end
      if (SEL_HI >= LFSR_W || SEL_LO >= LFSR_W || SEL_HI == SEL_LO) begin : g_chk_sel
         $error("chaos_bit_gen: selector taps out of range");
      end
      if (DEFAULT_SEED == '0) begin : g_chk_seed
         $error("chaos_bit_gen: DEFAULT_SEED must be nonzero");
      end
   endgenerate

   logic [STATE_W-1:0] state_q;
   logic [STATE_W-1:0] state_nx;
   logic [STATE_W-1:0] seed_fix;
   logic [LFSR_W-1:0]  lfsr_q;
   logic [1:0]         sel_idx;
   logic [2:0]         code;
   logic               do_step;
   logic               bit_q;
   logic               valid_q;

   assign do_step  = step_en & ~seed_load;
   assign seed_fix = (seed_val == '0) ? DEFAULT_SEED : seed_val;
   assign sel_idx  = {lfsr_q[SEL_HI], lfsr_q[SEL_LO]};

   chaos_lfsr #(.W(LFSR_W), .INIT(LFSR_INIT)) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (seed_load),
      .advance (do_step),
      .q       (lfsr_q)
   );

   chaos_slope_sel #(.DECODE_STYLE(DECODE_STYLE)) u_sel (
      .idx  (sel_idx),
      .code (code)
   );

   chaos_map_step #(.N(STATE_W), .MAP_STYLE(MAP_STYLE)) u_map (
      .k      (state_q),
      .code   (code),
      .k_next (state_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DEFAULT_SEED;
         bit_q   <= 1'b0;
         valid_q <= 1'b0;
      end else if (seed_load) begin
         state_q <= seed_fix;
         bit_q   <= 1'b0;
         valid_q <= 1'b0;
      end else if (step_en) begin
         state_q <= state_nx;
         bit_q   <= state_nx[MSB];
         valid_q <= 1'b1;
      end else begin
         valid_q <= 1'b0;
      end
   end

   assign rnd_bit   = bit_q;
   assign rnd_valid = valid_q;
endmodule

// File: rtl/chaos_bit_gen_chk.sv
module chaos_bit_gen_chk #(
   parameter int                 STATE_W      = 16,
   parameter int                 LFSR_W       = 5,
   parameter logic [STATE_W-1:0] DEFAULT_SEED = 16'hACE1,
   parameter logic [LFSR_W-1:0]  LFSR_INIT    = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               seed_load,
   input logic [STATE_W-1:0] seed_val,
   input logic               step_en,
   input logic               rnd_bit,
   input logic               rnd_valid,
   input logic [STATE_W-1:0] state,
   input logic [LFSR_W-1:0]  lfsr
);
   AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (seed_load && seed_val != '0) |=> (state == $past(seed_val) && !rnd_valid)); // R2
   AST_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n) seed_load |=> (lfsr == LFSR_INIT)); // R2
   AST_ZERO_SEED_SWAP: assert property (@(posedge clk) disable iff (!rst_n) (seed_load && seed_val == '0) |=> (state == DEFAULT_SEED)); // R3
   AST_SEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) (lfsr != '0)); // R6
   AST_SEL_MOVES: assert property (@(posedge clk) disable iff (!rst_n) (step_en && !seed_load) |=> (lfsr != $past(lfsr))); // R6
   AST_VALID_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n) (step_en && !seed_load) |=> rnd_valid); // R7
   AST_BIT_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n) rnd_valid |-> (rnd_bit == state[STATE_W-1])); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!step_en && !seed_load) |=> ($stable(state) && $stable(lfsr) && !rnd_valid)); // R8
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n) (seed_load && step_en) |=> !rnd_valid); // R9
endmodule

bind chaos_bit_gen chaos_bit_gen_chk #(
   .STATE_W      (STATE_W),
   .LFSR_W       (LFSR_W),
   .DEFAULT_SEED (DEFAULT_SEED),
   .LFSR_INIT    (LFSR_INIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .seed_load (seed_load),
   .seed_val  (seed_val),
   .step_en   (step_en),
   .rnd_bit   (rnd_bit),
   .rnd_valid (rnd_valid),
   .state     (state_q),
   .lfsr      (lfsr_q)
);

// File: tb/sim_chaos_bit_gen.sv
module sim_chaos_bit_gen;
   localparam int            N   = 16;
   localparam logic [N-1:0]  DEF = 16'hACE1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         seed_load = 1'b0;
   logic [N-1:0] seed_val = '0;
   logic         step_en = 1'b0;
   logic         rnd_bit;
   logic         rnd_valid;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [N-1:0] m_k   = DEF;
   logic [4:0]   m_sel = 5'b00001;

   logic  q_valid[$];
   logic  q_bit[$];
   string q_tag[$];

   always #5 clk = ~clk;

   chaos_bit_gen u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .seed_load (seed_load),
      .seed_val  (seed_val),
      .step_en   (step_en),
      .rnd_bit   (rnd_bit),
      .rnd_valid (rnd_valid)
   );

   function automatic logic [2:0] code_of(input logic [1:0] idx);
      case (idx)
         2'd0:    return 3'b111;
         2'd1:    return 3'b011;
         2'd2:    return 3'b110;
         default: return 3'b010;
      endcase
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // driver: apply one cycle of inputs and queue the predicted result
   task automatic drive(input logic ld, input logic en, input logic [N-1:0] sd, input string tag);
      logic [2*N-1:0] beta;
      logic [3*N-1:0] prod;
      @(negedge clk);
      seed_load = ld;
      step_en   = en;
      seed_val  = sd;
      if (ld) begin
         m_k   = (sd == '0) ? DEF : sd;          // R2 R3
         m_sel = 5'b00001;
         q_valid.push_back(1'b0); q_bit.push_back(1'b0); q_tag.push_back(tag);
      end else if (en) begin
         beta  = {code_of({m_sel[4], m_sel[1]}), {(N-3){1'b0}}, {N{1'b1}}}; // R5
         prod  = (3*N)'(beta) * (3*N)'(m_k);
         m_k   = prod[2*N-1:N];                   // R4
         m_sel = {m_sel[3:0], m_sel[4] ^ m_sel[2]}; // R6
         q_valid.push_back(1'b1); q_bit.push_back(m_k[N-1]); q_tag.push_back(tag); // R7
      end else begin
         q_valid.push_back(1'b0); q_bit.push_back(1'b0); q_tag.push_back(tag); // R8
      end
   endtask

   // monitor: one prediction per rising edge
   initial begin
      forever begin
         @(posedge clk);
         #3;
         if (q_valid.size() > 0) begin
            logic  ev;
            logic  eb;
            string tg;
            ev = q_valid.pop_front();
            eb = q_bit.pop_front();
            tg = q_tag.pop_front();
            check({tg, " valid"}, rnd_valid, ev);
            if (ev) check({tg, " bit"}, rnd_bit, eb);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset valid", rnd_valid, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", rnd_valid, 1'b0);
      for (int i = 0; i < 24; i++) drive(1'b0, 1'b1, '0, "R1 R4 R5 R6 run from reset");
      for (int i = 0; i < 3; i++)  drive(1'b0, 1'b0, 16'h5555, "R8 idle");
      for (int i = 0; i < 12; i++) drive(1'b0, 1'b1, '0, "R8 resume");
      drive(1'b1, 1'b0, 16'h1234, "R2 load");
      for (int i = 0; i < 40; i++) drive(1'b0, 1'b1, '0, "R2 R4 R5 after seed");
      drive(1'b1, 1'b0, 16'h0000, "R3 zero load");
      for (int i = 0; i < 20; i++) drive(1'b0, 1'b1, '0, "R3 after zero seed");
      drive(1'b1, 1'b1, 16'hBEEF, "R9 load with step");
      for (int i = 0; i < 20; i++) drive(1'b0, 1'b1, '0, "R9 after load");
      for (int i = 0; i < 40; i++) drive(1'b0, (i % 3) != 1, 16'hFFFF, "R6 R8 gapped steps");
      drive(1'b1, 1'b0, 16'h8001, "R2 load top bit");
      for (int i = 0; i < 40; i++) drive(1'b0, 1'b1, '0, "R4 R7 from 8001");
      drive(1'b0, 1'b0, '0, "R8 drain");
      drive(1'b0, 1'b0, '0, "R8 drain");
      @(negedge clk);
      finish_run();
   end
endmodule